// File: doc/BRIEF.md
# Mapped Block Transfer Engine

This block moves a run of bytes or 16-bit words between a device-side stream and a 16-bit wide memory addressed in words. A transfer is launched with a bus address, a byte count, a direction, a byte/word selector and a map-enable flag. When the map is enabled, every element's bus address is presented on a translate port and the returned physical address is used. When the map is off, the bus address is used as the physical address directly.

Addresses at or above the installed memory size, given as a byte count on an input, are never accessed. The two address modes deal with them differently. A mapped transfer stops at the first element whose translated address falls outside memory. A physical transfer is clipped at the top of memory before it starts. In both cases the engine reports how many bytes were not moved.

Memory-bound data arrives on a valid/ready input stream. Device-bound data leaves on a valid/ready output stream. Completion is flagged by a single-cycle pulse, and the residual byte count stays on its output until the next completion.

Top module: `dma_block_mover`

## Requirements
- R1: In word mode (`byte_mode_i`=0), bit 0 of the address and bit 0 of the count are cleared at start. Every access enables both byte lanes (`mem_be_o`=2'b11), and the address advances by 2 per element.
- R2: In byte mode, an odd physical byte address uses lane 1 (`mem_be_o`=2'b10, data on bits 15:8), and an even one uses lane 0 (2'b01, bits 7:0). A byte write leaves the other byte of the word unchanged. A byte read returns the selected byte on `m_data_o[7:0]` with bits 15:8 zero. Memory-bound bytes are taken from `s_data_i[7:0]`.
- R3: With the map on, the low 18 bits of the input address form the bus address shown on `map_addr_o`. With the map off, the low 22 bits of the input address are used as the physical address.
- R4: With the map on, each element is translated on its own. At the first element whose translated address is at or above `mem_size_i`, the transfer stops, and the residual is the bytes not yet moved. All earlier elements are moved.
- R5: A mapped transfer that reaches its end reports a residual of 0.
- R6: With the map off and start plus count not beyond `mem_size_i`, the whole block moves and the residual is 0.
- R7: With the map off, a start inside memory and an end beyond it, elements move up to `mem_size_i`, and the residual is start plus count minus `mem_size_i`.
- R8: With the map off and a start at or above `mem_size_i`, no memory access takes place and the residual equals the (aligned) count.
- R9: `done_o` is high for exactly one cycle per transfer. `resid_o` changes only in the cycle `done_o` rises and holds until the next completion. After reset `resid_o` is 0.
- R10: Each moved element costs exactly one memory access. A stream item is taken only when valid and ready are both high. Output data stays stable while `m_valid_o` is high and `m_ready_i` is low.
- R11: No access is made to a byte address at or above `mem_size_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a transfer (taken only when idle) |
| to_mem_i | input | 1 | 1: stream to memory, 0: memory to stream |
| byte_mode_i | input | 1 | 1: byte elements, 0: word elements |
| map_en_i | input | 1 | 1: translate each address through the map port |
| bus_addr_i | input | 24 | Starting bus address in bytes |
| byte_count_i | input | 16 | Bytes requested |
| mem_size_i | input | 23 | Installed memory in bytes |
| map_addr_o | output | 18 | Bus address to translate |
| map_pa_i | input | 22 | Translated physical byte address (combinational reply) |
| mem_en_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_be_o | output | 2 | Byte lane enables |
| mem_addr_o | output | 21 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after the read |
| s_valid_i | input | 1 | Memory-bound item valid |
| s_data_i | input | 16 | Memory-bound item |
| s_ready_o | output | 1 | Engine takes the item this cycle |
| m_valid_o | output | 1 | Device-bound item valid |
| m_data_o | output | 16 | Device-bound item |
| m_ready_i | input | 1 | Device takes the item |
| done_o | output | 1 | One-cycle completion pulse |
| resid_o | output | 16 | Bytes not moved by the last transfer |

## Verification
The assertions assume a memory that returns read data one cycle after an enabled read and holds it while not enabled. They also assume that `map_pa_i` answers the current `map_addr_o` within the same cycle, and that `mem_size_i` and the map contents stay steady while a transfer runs. The bench's memory model keeps read data between reads, its map is a combinational offset adder, and the bench changes memory size and map offset only between transfers. Stream stall patterns vary per cycle so that the output hold and the paced input acceptance are both exercised.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} dma_state_e;

  // lane enables of one element: word uses both, byte picks by address bit 0
  function automatic logic [1:0] lane_enables(input logic word, input logic odd);
    if (word) return 2'b11;
    return odd ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/dma_plan.sv
// Start-time setup: trim, align, and clip a physical run at the memory top.
module dma_plan #(
  parameter int ADDR_IN_W = 24,
  parameter int PA_W      = 22,
  parameter int MAP_W     = 18,
  parameter int CNT_W     = 16
) (
  input  logic [ADDR_IN_W-1:0] addr_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 word_i,
  input  logic                 mapped_i,
  input  logic [PA_W:0]        mem_size_i,
  output logic [PA_W-1:0]      first_ba_o,
  output logic [CNT_W-1:0]     move_o,
  output logic [CNT_W-1:0]     clip_o
);
  localparam int LIM_W = PA_W + 1;

  logic [PA_W-1:0]  ba_trim;
  logic [PA_W-1:0]  ba_al;
  logic [CNT_W-1:0] cnt_al;
  logic [LIM_W-1:0] lim;

  always_comb begin
    ba_trim = mapped_i ? PA_W'(addr_i[MAP_W-1:0]) : addr_i[PA_W-1:0];
    ba_al   = word_i ? {ba_trim[PA_W-1:1], 1'b0} : ba_trim;
    cnt_al  = word_i ? {cnt_i[CNT_W-1:1], 1'b0} : cnt_i;
    lim     = {1'b0, ba_al} + LIM_W'(cnt_al);
    first_ba_o = ba_al;
    if (mapped_i) begin
      move_o = cnt_al;
      clip_o = '0;
    end else if ({1'b0, ba_al} >= mem_size_i) begin
      move_o = '0;
      clip_o = cnt_al;
    end else if (lim <= mem_size_i) begin
      move_o = cnt_al;
      clip_o = '0;
    end else begin
      move_o = CNT_W'(mem_size_i - {1'b0, ba_al});
      clip_o = CNT_W'(lim - mem_size_i);
    end
  end
endmodule

// File: rtl/dma_lane.sv
// Per-element address path: pick translated or direct address, range check, lanes.
module dma_lane #(
  parameter int PA_W = 22
) (
  input  logic [PA_W-1:0] cur_ba_i,
  input  logic            mapped_i,
  input  logic [PA_W-1:0] map_pa_i,
  input  logic [PA_W:0]   mem_size_i,
  input  logic            word_i,
  output logic            odd_o,
  output logic            in_mem_o,
  output logic [1:0]      be_o,
  output logic [PA_W-2:0] waddr_o
);
  import dma_pkg::*;

  logic [PA_W-1:0] pa;

  always_comb begin
    pa       = mapped_i ? map_pa_i : cur_ba_i;
    if (word_i) pa[0] = 1'b0;
    in_mem_o = {1'b0, pa} < mem_size_i;
    odd_o    = pa[0];
    be_o     = lane_enables(word_i, pa[0]);
    waddr_o  = pa[PA_W-1:1];
  end
endmodule

// File: rtl/dma_rdout.sv
// Device-bound output register fed by the one-cycle memory read.
module dma_rdout #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  logic          odd_i,
  input  logic          word_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          m_ready_i,
  output logic          room_o,
  output logic          idle_o,
  output logic          m_valid_o,
  output logic [DW-1:0] m_data_o
);
  localparam int HW = DW / 2;

  logic pend_q, pend_odd_q, pend_word_q;
  logic stuck, load;
  logic [DW-1:0] sel;

  always_comb begin
    stuck  = m_valid_o && !m_ready_i;
    load   = pend_q && !stuck;
    room_o = !pend_q || !stuck;
    idle_o = !pend_q && !m_valid_o;
    if (pend_word_q) sel = rdata_i;
    else sel = {{HW{1'b0}}, pend_odd_q ? rdata_i[DW-1:HW] : rdata_i[HW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_odd_q  <= 1'b0;
      pend_word_q <= 1'b0;
      m_valid_o   <= 1'b0;
      m_data_o    <= '0;
    end else begin
      pend_q <= issue_i || (pend_q && stuck);
      if (issue_i) begin
        pend_odd_q  <= odd_i;
        pend_word_q <= word_i;
      end
      if (load) begin
        m_valid_o <= 1'b1;
        m_data_o  <= sel;
      end else if (m_ready_i) begin
        m_valid_o <= 1'b0;
      end
    end
  end

  // R10: a stalled output item neither vanishes nor changes
  a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));
endmodule

// File: rtl/dma_block_mover.sv
module dma_block_mover #(
  parameter int ADDR_IN_W = 24,
  parameter int PA_W      = 22,
  parameter int MAP_W     = 18,
  parameter int CNT_W     = 16,
  parameter int DW        = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 to_mem_i,
  input  logic                 byte_mode_i,
  input  logic                 map_en_i,
  input  logic [ADDR_IN_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]     byte_count_i,
  input  logic [PA_W:0]        mem_size_i,
  output logic [MAP_W-1:0]     map_addr_o,
  input  logic [PA_W-1:0]      map_pa_i,
  output logic                 mem_en_o,
  output logic                 mem_we_o,
  output logic [1:0]           mem_be_o,
  output logic [PA_W-2:0]      mem_addr_o,
  output logic [DW-1:0]        mem_wdata_o,
  input  logic [DW-1:0]        mem_rdata_i,
  input  logic                 s_valid_i,
  input  logic [DW-1:0]        s_data_i,
  output logic                 s_ready_o,
  output logic                 m_valid_o,
  output logic [DW-1:0]        m_data_o,
  input  logic                 m_ready_i,
  output logic                 done_o,
  output logic [CNT_W-1:0]     resid_o
);
  import dma_pkg::*;

  localparam int HW = DW / 2;

  dma_state_e       state_q;
  logic [PA_W-1:0]  cur_ba_q;
  logic [CNT_W-1:0] left_q, clip_q, rem_q;
  logic             word_q, mapped_q, to_mem_q;

  logic [PA_W-1:0]  plan_ba;
  logic [CNT_W-1:0] plan_move, plan_clip;
  logic [CNT_W-1:0] step;
  logic             more, in_mem, odd, elem_ok, wr_fire, rd_issue, access;
  logic             rd_room, rd_idle;
  logic [1:0]       be;
  logic [PA_W-2:0]  waddr;

  dma_plan #(.ADDR_IN_W(ADDR_IN_W), .PA_W(PA_W), .MAP_W(MAP_W), .CNT_W(CNT_W)) u_plan (
    .addr_i     (bus_addr_i),
    .cnt_i      (byte_count_i),
    .word_i     (!byte_mode_i),
    .mapped_i   (map_en_i),
    .mem_size_i (mem_size_i),
    .first_ba_o (plan_ba),
    .move_o     (plan_move),
    .clip_o     (plan_clip)
  );

  dma_lane #(.PA_W(PA_W)) u_lane (
    .cur_ba_i   (cur_ba_q),
    .mapped_i   (mapped_q),
    .map_pa_i   (map_pa_i),
    .mem_size_i (mem_size_i),
    .word_i     (word_q),
    .odd_o      (odd),
    .in_mem_o   (in_mem),
    .be_o       (be),
    .waddr_o    (waddr)
  );

  dma_rdout #(.DW(DW)) u_rdout (
    .clk       (clk),
    .rst       (rst),
    .issue_i   (rd_issue),
    .odd_i     (odd),
    .word_i    (word_q),
    .rdata_i   (mem_rdata_i),
    .m_ready_i (m_ready_i),
    .room_o    (rd_room),
    .idle_o    (rd_idle),
    .m_valid_o (m_valid_o),
    .m_data_o  (m_data_o)
  );

  always_comb begin
    step        = word_q ? CNT_W'(2) : CNT_W'(1);
    more        = left_q >= step;
    elem_ok     = (state_q == ST_RUN) && more && in_mem;
    s_ready_o   = elem_ok && to_mem_q;
    wr_fire     = s_ready_o && s_valid_i;
    rd_issue    = elem_ok && !to_mem_q && rd_room;
    access      = wr_fire || rd_issue;
    map_addr_o  = cur_ba_q[MAP_W-1:0];
    mem_en_o    = access;
    mem_we_o    = wr_fire;
    mem_be_o    = be;
    mem_addr_o  = waddr;
    mem_wdata_o = word_q ? s_data_i : {s_data_i[HW-1:0], s_data_i[HW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cur_ba_q <= '0;
      left_q   <= '0;
      clip_q   <= '0;
      rem_q    <= '0;
      word_q   <= 1'b1;
      mapped_q <= 1'b0;
      to_mem_q <= 1'b0;
      resid_o  <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cur_ba_q <= plan_ba;
          left_q   <= plan_move;
          clip_q   <= plan_clip;
          word_q   <= !byte_mode_i;
          mapped_q <= map_en_i;
          to_mem_q <= to_mem_i;
          state_q  <= ST_RUN;
        end
        ST_RUN: begin
          if (access) begin
            cur_ba_q <= cur_ba_q + PA_W'(step);
            left_q   <= left_q - step;
          end
          if (!(more && in_mem)) begin
            rem_q   <= more ? left_q : clip_q;
            state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (rd_idle) begin
          resid_o <= rem_q;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9: residual only moves together with the completion pulse
  a_r9_resid_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(resid_o));
  // R11: every enabled lane lies below the installed size
  a_r11_in_memory: assert property (@(posedge clk) disable iff (rst)
    mem_en_o |-> ({1'b0, mem_addr_o, mem_be_o == 2'b10} < mem_size_i));
  // R1: word elements drive both lanes
  a_r1_word_lanes: assert property (@(posedge clk) disable iff (rst)
    (mem_en_o && word_q) |-> (mem_be_o == 2'b11));
  // R2: byte elements drive exactly one lane
  a_r2_byte_lane: assert property (@(posedge clk) disable iff (rst)
    (mem_en_o && !word_q) |-> ($countones(mem_be_o) == 1));
  // R10: a stream item is taken only by a write access
  a_r10_take_writes: assert property (@(posedge clk) disable iff (rst)
    (s_ready_o && s_valid_i) |-> (mem_en_o && mem_we_o));
endmodule

// File: tb/dma_block_mover_tb.sv
`timescale 1ns/1ps
module dma_block_mover_tb;
  localparam int MW = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, to_mem = 1'b0, byte_m = 1'b0, map_en = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] cnt = '0;
  logic [22:0] msize = 23'd2048;
  logic [17:0] map_addr;
  logic [21:0] map_pa, map_base = '0;
  logic        mem_en, mem_we;
  logic [1:0]  mem_be;
  logic [20:0] mem_addr;
  logic [15:0] mem_wdata, rdata_q;
  logic        s_valid = 1'b0, s_ready, m_valid, m_ready = 1'b1, done;
  logic [15:0] s_data = '0, m_data, resid;

  logic [15:0] mem    [0:MW-1];
  logic [15:0] shadow [0:MW-1];
  logic [15:0] exp_q [$];

  int n_chk = 0, n_bad = 0, mon_chk = 0, mon_bad = 0;
  int done_cnt = 0, acc_cnt = 0, last_resid = 0;
  logic prev_done = 1'b0;
  string cur_tag = "reset";

  always #2.5 clk = ~clk;

  assign map_pa = {4'b0, map_addr} + map_base;

  dma_block_mover u_dut (
    .clk(clk), .rst(rst), .start_i(start), .to_mem_i(to_mem), .byte_mode_i(byte_m),
    .map_en_i(map_en), .bus_addr_i(bus_addr), .byte_count_i(cnt), .mem_size_i(msize),
    .map_addr_o(map_addr), .map_pa_i(map_pa), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_be_o(mem_be), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(rdata_q), .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .m_valid_o(m_valid), .m_data_o(m_data), .m_ready_i(m_ready), .done_o(done),
    .resid_o(resid)
  );

  function automatic logic [15:0] pat_mem(input int i);
    return 16'(i * 16'h0107) ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] pat_src(input int i);
    return 16'(i * 16'h1F3) ^ 16'hC3A1;
  endfunction

  // memory model: one-cycle read, data held while not enabled
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MW; i++) mem[i] <= pat_mem(i);
      rdata_q <= '0;
    end else if (mem_en) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mem_addr[9:0]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr[9:0]][15:8] <= mem_wdata[15:8];
      end else begin
        rdata_q <= mem[mem_addr[9:0]];
      end
    end
  end

  // monitor: scoreboard pop for device-bound items, done capture
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_en) acc_cnt++;
      if (m_valid && m_ready) begin
        mon_chk++;
        if (exp_q.size() == 0) begin
          mon_bad++;
          $display("FAIL %s R10: unexpected item %h expected none", cur_tag, m_data);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          if (m_data !== e) begin
            mon_bad++;
            $display("FAIL %s R2/R10 data: got %h expected %h", cur_tag, m_data, e);
          end
        end
      end
      if (done) begin
        done_cnt++;
        last_resid = resid;
      end
      if (done && prev_done) begin
        mon_chk++;
        mon_bad++;
        $display("FAIL %s R9: done high %0d expected 1 cycle", cur_tag, 2);
      end
      prev_done = done;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run_xfer(input string tag, input bit wr, input bit bm, input bit mp,
                          input logic [23:0] a, input int c_in, input int ms,
                          input logic [21:0] base);
    int ba, c, step, e, n, movable, clip, lim, pa, res, sent, d0, acc0, t, wi, diff;
    logic [7:0] lf;
    logic [15:0] d;
    cur_tag = tag;
    step = bm ? 1 : 2;
    ba = mp ? int'(a[17:0]) : int'(a[21:0]);
    c  = c_in;
    if (!bm) begin ba = ba & ~1; c = c & ~1; end
    lim = ba + c;
    movable = 0; clip = 0;
    if (!mp) begin
      if (ba >= ms) begin movable = 0; clip = c; end
      else if (lim <= ms) begin movable = c; clip = 0; end
      else begin movable = ms - ba; clip = lim - ms; end
    end
    e = 0; n = 0;
    while (e < c) begin
      if (mp) begin
        pa = ((ba + e) & 32'h3FFFF) + int'(base);
        if (pa >= ms) break;
      end else begin
        if (e + step > movable) break;
        pa = ba + e;
      end
      if (!bm) pa = pa & ~1;
      if (wr) begin
        d = pat_src(n);
        if (!bm) shadow[pa >> 1] = d;
        else if (pa[0]) shadow[pa >> 1][15:8] = d[7:0];
        else shadow[pa >> 1][7:0] = d[7:0];
      end else begin
        if (!bm) exp_q.push_back(shadow[pa >> 1]);
        else exp_q.push_back({8'h00, pa[0] ? shadow[pa >> 1][15:8] : shadow[pa >> 1][7:0]});
      end
      n++;
      e += step;
    end
    res = mp ? (c - e) : clip;

    @(posedge clk); #1;
    map_base = base; msize = 23'(ms);
    to_mem = wr; byte_m = bm; map_en = mp; bus_addr = a; cnt = 16'(c_in);
    start = 1'b1;
    d0 = done_cnt; acc0 = acc_cnt;
    @(posedge clk); #1;
    start = 1'b0;
    sent = 0; t = 0; lf = 8'hA7;
    while (done_cnt == d0 && t < 4000) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      d = pat_src(sent);
      s_valid = wr && (sent < n) && (lf[0] || lf[2]);
      s_data  = bm ? {~d[7:0], d[7:0]} : d;
      m_ready = lf[1] || lf[6];
      @(negedge clk);
      if (s_valid && s_ready) sent++;
      @(posedge clk); #1;
      t++;
    end
    s_valid = 1'b0; m_ready = 1'b1;
    if (t >= 4000) begin
      n_chk++; n_bad++;
      $display("FAIL %s watchdog: done count %0d expected %0d", tag, done_cnt, d0 + 1);
    end
    chk({tag, " residual"}, last_resid, res);
    chk({tag, " R10 accesses"}, acc_cnt - acc0, n);
    chk({tag, " R10 items left"}, exp_q.size(), 0);
    diff = 0;
    for (int i = 0; i < MW; i++) if (mem[i] !== shadow[i] && diff == 0) begin diff = 1; wi = i; end
    if (diff != 0) begin
      n_chk++; n_bad++;
      $display("FAIL %s memory word %0d: got %h expected %h", tag, wi, mem[wi], shadow[wi]);
    end else n_chk++;
    exp_q.delete();
  endtask

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_chk + 1,
             n_bad + mon_bad + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < MW; i++) shadow[i] = pat_mem(i);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset resid", int'(resid), 0);
    chk("R10 reset m_valid", int'(m_valid), 0);
    chk("R10 reset s_ready", int'(s_ready), 0);
    chk("R11 reset mem_en", int'(mem_en), 0);

    run_xfer("R6 R1 phys word write",   1, 0, 0, 24'h000100, 16,   2048, '0);
    run_xfer("R6 R10 phys word read",   0, 0, 0, 24'h000100, 16,   2048, '0);
    run_xfer("R2 phys byte write odd",  1, 1, 0, 24'h000201, 5,    2048, '0);
    run_xfer("R2 phys byte read odd",   0, 1, 0, 24'h000201, 7,    2048, '0);
    run_xfer("R1 word align odd",       1, 0, 0, 24'h000301, 7,    2048, '0);
    run_xfer("R7 phys clip write",      1, 0, 0, 24'h0003F8, 20,   1024, '0);
    run_xfer("R7 phys clip read",       0, 0, 0, 24'h0003FC, 10,   1024, '0);
    run_xfer("R8 phys start outside",   1, 0, 0, 24'h000500, 10,   1024, '0);
    run_xfer("R8 phys outside read",    0, 1, 0, 24'h000600, 9,    1024, '0);
    run_xfer("R6 phys zero count",      1, 1, 0, 24'h000010, 0,    2048, '0);
    run_xfer("R3 phys trim 22",         1, 0, 0, 24'hC00040, 12,   2048, '0);
    run_xfer("R5 R3 mapped word read",  0, 0, 1, 24'hFC0010, 24,   2048, 22'h000100);
    run_xfer("R5 mapped byte write",    1, 1, 1, 24'h000033, 9,    2048, 22'h000200);
    run_xfer("R4 mapped word write stop", 1, 0, 1, 24'h000010, 32, 1024, 22'h0003E0);
    run_xfer("R4 mapped byte read stop",  0, 1, 1, 24'h000020, 20, 1024, 22'h0003D8);

    // R9: residual holds after the pulse
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 resid held", int'(resid), 12);
    chk("R9 done low", int'(done), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_chk,
             n_bad + mon_bad);
    $finish;
  end
endmodule